// File: doc/BRIEF.md
# List-Filled Handshake and Soft-Reset Controller

This block holds the command-status bits that a USB host controller's schedule engine uses to decide whether to walk its control list and its bulk list. Each list has a "filled" flag. Software raises the flag after it links a new transfer descriptor onto that list. When the engine starts a list, the flag is consumed: it is cleared, and the list is walked only if the flag was set. Each descriptor the engine finds raises the flag again, so the list is walked again on the next pass. A pass that ends with the flag still clear stops the processing of that list.

The same register carries a soft-reset request. Writing it starts a reset of fixed length, measured in clock cycles. During the reset the bit reads back as set, host bus traffic is blocked, and both lists are idle. When the reset ends, the controller's functional state is suspend. A small control register holds the functional state and an interrupt-routing bit, and the routing bit keeps its value through the soft reset.

Top module: `hcs_cmd_status`

## Requirements
- R1: After the synchronous reset, both registers read 0, both list walk outputs are 0 and bus_block is 0. In the command-status register (reg_addr 0), bit 0 is the soft-reset busy bit, bit 1 is the control-list flag, bit 2 is the bulk-list flag, and bits 31:3 read 0.
- R2: A write to reg_addr 0 with bit 1 or bit 2 set raises the matching list flag from the next cycle on. A 0 in those bits leaves the flag unchanged.
- R3: A start strobe on a list whose flag is 0 leaves that list's walk output at 0 on the next cycle, so the list is skipped.
- R4: A start strobe on a list whose flag is 1 sets its walk output to 1 and clears its flag on the next cycle.
- R5: A found strobe sets the list's flag on the next cycle. An end strobe clears the walk output on the next cycle. A pass that ends with the flag still 0 leads to a skip at the next start.
- R6: If a software set or a found strobe arrives in the same cycle as a start strobe, the flag is 1 afterwards. The walk output still follows the flag value from before that cycle.
- R7: List 0 (control) and list 1 (bulk) are independent. Strobes or sets on one list never change the other list's outputs.
- R8: Writing 1 to bit 0 of reg_addr 0 sets bit 0 and bus_block from the next cycle on, for exactly RST_CYCLES cycles, and then clears them. The default of 400 cycles is well under the 2000 cycles that make up 10 µs at 200 MHz.
- R9: Entering the soft reset clears both flags and both walk outputs and sets the state field to suspend (3). The routing bit keeps its value.
- R10: While the soft reset runs, register writes and engine strobes have no effect.
- R11: When idle, a write to reg_addr 1 loads bits 1:0 (functional state: 0 reset, 1 resume, 2 operational, 3 suspend) and bit 2 (routing). These read back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = command-status, 1 = control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lst_start | input | 2 | Start-of-list strobe per list (0 control, 1 bulk) |
| lst_found | input | 2 | Descriptor-found strobe per list |
| lst_end | input | 2 | End-of-list strobe per list |
| lst_walk | output | 2 | List is being walked |
| lst_pending | output | 2 | Current list-filled flag per list |
| bus_block | output | 1 | Host bus traffic blocked during soft reset |

## Verification
Every state change is a single register stage. A flag, walk output, busy bit or control field is due exactly one cycle after the strobe or write that causes it, and reg_rdata follows that state with no extra delay. The bench drives inputs on the falling edge and samples on the next falling edge, which sits half a period after the updating rising edge. The soft-reset length is checked by counting falling edges while bus_block is high and comparing the count with RST_CYCLES. The handshake is swept over every combination of list, prior flag value, software set and found strobe at the start strobe.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int NLIST   = 2;
    localparam int REG_W   = 32;

    localparam int BIT_RST = 0;
    localparam int BIT_CTL = 1;
    localparam int BIT_BLK = 2;

    localparam int CTRL_ROUTE_BIT = 2;

    typedef enum logic [1:0] {
        FS_RESET   = 2'd0,
        FS_RESUME  = 2'd1,
        FS_OPER    = 2'd2,
        FS_SUSPEND = 2'd3
    } fstate_e;

    typedef struct packed {
        logic start;
        logic found;
        logic last;
        logic sw_set;
    } lst_ev_t;

    typedef struct packed {
        logic walk;
        logic filled;
    } lst_st_t;

    function automatic int flag_pos(input int idx);
        return BIT_CTL + idx;
    endfunction

endpackage

// File: rtl/hcs_list_flag.sv
module hcs_list_flag
    import hcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_clr,
    input  lst_ev_t ev,
    output lst_st_t st
);

    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            st <= '0;
        end else begin
            if (ev.start)
                st.walk <= st.filled;
            else if (ev.last)
                st.walk <= 1'b0;

            if (ev.sw_set || ev.found)
                st.filled <= 1'b1;
            else if (ev.start)
                st.filled <= 1'b0;
        end
    end

    p_skip_r3: assert property (@(posedge clk) disable iff (rst || hold_clr)
        (ev.start && !st.filled) |=> !st.walk);

    p_take_r4: assert property (@(posedge clk) disable iff (rst || hold_clr)
        (ev.start && st.filled && !ev.sw_set && !ev.found) |=> (st.walk && !st.filled));

    p_found_r5: assert property (@(posedge clk) disable iff (rst || hold_clr)
        ev.found |=> st.filled);

    p_end_r5: assert property (@(posedge clk) disable iff (rst || hold_clr)
        (ev.last && !ev.start) |=> !st.walk);

    p_setwins_r6: assert property (@(posedge clk) disable iff (rst || hold_clr)
        (ev.sw_set && ev.start) |=> st.filled);

endmodule

// File: rtl/hcs_reset_seq.sv
module hcs_reset_seq #(
    parameter int RST_CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic enter,
    output logic busy
);

    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign enter = req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (enter) begin
            busy <= 1'b1;
            cnt  <= CW'(RST_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    // independent age counter for the bounded-duration check
    logic [CW:0] age;
    always_ff @(posedge clk) begin
        if (rst || !busy)
            age <= '0;
        else
            age <= age + 1'b1;
    end

    p_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (age < (CW+1)'(RST_CYCLES)));

    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);

    p_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req));

endmodule

// File: rtl/hcs_ctrl_reg.sv
module hcs_ctrl_reg
    import hcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enter,
    input  logic       wr,
    input  logic [2:0] wdata,
    output fstate_e    state,
    output logic       route
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_RESET;
            route <= 1'b0;
        end else if (enter) begin
            state <= FS_SUSPEND;
        end else if (wr) begin
            state <= fstate_e'(wdata[1:0]);
            route <= wdata[CTRL_ROUTE_BIT];
        end
    end

    p_keep_route_r9: assert property (@(posedge clk) disable iff (rst)
        enter |=> (state == FS_SUSPEND && route == $past(route)));

    p_load_r11: assert property (@(posedge clk) disable iff (rst)
        (wr && !enter) |=> (route == $past(wdata[CTRL_ROUTE_BIT])));

endmodule

// File: rtl/hcs_cmd_status.sv
module hcs_cmd_status
    import hcs_pkg::*;
#(
    parameter int RST_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NLIST-1:0]  lst_start,
    input  logic [NLIST-1:0]  lst_found,
    input  logic [NLIST-1:0]  lst_end,
    output logic [NLIST-1:0]  lst_walk,
    output logic [NLIST-1:0]  lst_pending,
    output logic              bus_block
);

    logic    busy;
    logic    enter;
    logic    soft_req;
    logic    wr_ok;
    logic    hold_clr;
    fstate_e fstate;
    logic    route;
    logic    unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:3];

    assign soft_req = reg_wr && !reg_addr && reg_wdata[BIT_RST];
    assign wr_ok    = reg_wr && !busy && !enter;
    assign hold_clr = enter || busy;

    hcs_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (soft_req),
        .enter (enter),
        .busy  (busy)
    );

    hcs_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .enter (enter),
        .wr    (wr_ok && reg_addr),
        .wdata (reg_wdata[2:0]),
        .state (fstate),
        .route (route)
    );

    for (genvar i = 0; i < NLIST; i++) begin : g_list
        lst_ev_t ev;
        lst_st_t st;

        assign ev.start  = lst_start[i];
        assign ev.found  = lst_found[i];
        assign ev.last   = lst_end[i];
        assign ev.sw_set = wr_ok && !reg_addr && reg_wdata[flag_pos(i)];

        hcs_list_flag u_flag (
            .clk      (clk),
            .rst      (rst),
            .hold_clr (hold_clr),
            .ev       (ev),
            .st       (st)
        );

        assign lst_walk[i]    = st.walk;
        assign lst_pending[i] = st.filled;
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[BIT_RST] = busy;
            reg_rdata[BIT_CTL] = lst_pending[0];
            reg_rdata[BIT_BLK] = lst_pending[1];
        end else begin
            reg_rdata[1:0]            = fstate;
            reg_rdata[CTRL_ROUTE_BIT] = route;
        end
    end

    assign bus_block = busy;

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (lst_walk == '0 && lst_pending == '0));

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:3] == '0);

    p_busy_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (!reg_addr) |-> (reg_rdata[BIT_RST] == bus_block));

endmodule

// File: tb/test_hcs_cmd_status.sv
`timescale 1ns/1ps
module test_hcs_cmd_status;

    localparam int RSTC = 400;
    localparam int LIMIT_10US = 2000; // 10 us / 5 ns

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic        reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  lst_start, lst_found, lst_end;
    logic [1:0]  lst_walk, lst_pending;
    logic        bus_block;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hcs_cmd_status #(.RST_CYCLES(RSTC)) i_hcs_cmd_status (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lst_start(lst_start), .lst_found(lst_found), .lst_end(lst_end),
        .lst_walk(lst_walk), .lst_pending(lst_pending), .bus_block(bus_block)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        lst_start = '0; lst_found = '0; lst_end = '0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a; #0.5; d = reg_rdata; reg_addr = 0;
    endtask

    task automatic strobe(input int i, input logic s, input logic f, input logic e);
        lst_start[i] = s; lst_found[i] = f; lst_end[i] = e;
        step();
    endtask

    // bring list i to flag=0, walk=0
    task automatic clear_list(input int i);
        strobe(i, 1, 0, 0);
        strobe(i, 0, 0, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cnt;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        step();

        // R1 reset state
        rd(0, v); chk("R1 cmd", v, 0);
        rd(1, v); chk("R1 ctrl", v, 0);
        chk("R1 walk", {30'd0, lst_walk}, 0);
        chk("R1 block", {31'd0, bus_block}, 0);

        // R2 software set, and zero bits leave flags alone
        wr(0, 32'h2); chk("R2 ctl set", {30'd0, lst_pending}, 2'b01);
        wr(0, 32'h0); chk("R2 zero write", {30'd0, lst_pending}, 2'b01);
        wr(0, 32'h4); rd(0, v); chk("R2 read both", v, 32'h6);

        // R3/R4/R6/R7 sweep
        for (int i = 0; i < 2; i++) begin
            for (int init = 0; init < 2; init++) begin
                for (int sw = 0; sw < 2; sw++) begin
                    for (int fd = 0; fd < 2; fd++) begin
                        logic [1:0] other_p, other_w;
                        clear_list(i);
                        if (init != 0) wr(0, 32'(1) << (1 + i));
                        other_p = lst_pending[1-i];
                        other_w = lst_walk[1-i];
                        lst_start[i] = 1; lst_found[i] = fd[0];
                        if (sw != 0) begin
                            reg_wr = 1; reg_wdata = 32'(1) << (1 + i);
                        end
                        step();
                        if (init == 0)
                            chk("R3 skip walk", {31'd0, lst_walk[i]}, 0);
                        else
                            chk("R4 take walk", {31'd0, lst_walk[i]}, 1);
                        if (sw == 0 && fd == 0)
                            chk("R4 flag consumed", {31'd0, lst_pending[i]}, 0);
                        else
                            chk("R6 set wins", {31'd0, lst_pending[i]}, 1);
                        chk("R7 other pending", {31'd0, lst_pending[1-i]}, {31'd0, other_p[0]});
                        chk("R7 other walk", {31'd0, lst_walk[1-i]}, {31'd0, other_w[0]});
                    end
                end
            end
        end

        // R5 multi-pass sequence on bulk list
        clear_list(1);
        wr(0, 32'h4);
        strobe(1, 1, 0, 0);
        chk("R5 walking", {30'd0, lst_walk[1], lst_pending[1]}, 2'b10);
        strobe(1, 0, 1, 0); chk("R5 found sets", {31'd0, lst_pending[1]}, 1);
        strobe(1, 0, 0, 1); chk("R5 end clears walk", {31'd0, lst_walk[1]}, 0);
        strobe(1, 1, 0, 0); chk("R5 second pass", {31'd0, lst_walk[1]}, 1);
        strobe(1, 0, 0, 1);
        strobe(1, 1, 0, 0); chk("R5 stop after empty pass", {31'd0, lst_walk[1]}, 0);

        // R11 control register
        wr(1, 32'h6); rd(1, v); chk("R11 ctrl load", v, 32'h6);
        wr(1, 32'h1); rd(1, v); chk("R11 ctrl reload", v, 32'h1);

        // setup for R9: route=1, operational, flags set, control walking
        wr(1, 32'h6);
        clear_list(0);
        wr(0, 32'h2);
        strobe(0, 1, 0, 0);
        wr(0, 32'h6);
        chk("R9 pre walk", {30'd0, lst_walk}, 2'b01);

        // R8 soft reset
        wr(0, 32'h1);
        rd(0, v); chk("R8 busy bit", v, 32'h1);
        chk("R8 block", {31'd0, bus_block}, 1);
        chk("R9 flags cleared", {30'd0, lst_pending}, 0);
        chk("R9 walk cleared", {30'd0, lst_walk}, 0);
        rd(1, v); chk("R9 suspend keeps route", v, 32'h7);

        // R10 ignored during reset
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'h6; lst_found = 2'b11;
        step();
        chk("R10 flags untouched", {30'd0, lst_pending}, 0);
        wr(1, 32'h0);
        rd(1, v); chk("R10 ctrl untouched", v, 32'h7);
        cnt = 2; // two busy cycles consumed by the writes above
        while (bus_block && cnt < RSTC + 10) begin
            cnt++;
            step();
        end
        chk("R8 duration", 32'(cnt), 32'(RSTC));
        chk("R8 within 10us", {31'd0, cnt < LIMIT_10US}, 1);
        rd(0, v); chk("R8 busy cleared", v, 0);
        strobe(0, 1, 0, 0); chk("R10 no pending after reset", {31'd0, lst_walk[0]}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule